// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block is one fan-speed measurement channel. A 16-bit up-counter runs from a selectable division of the system clock. A fan tachometer input is resynchronised, and each falling edge latches the running count into a capture register. The count then restarts from zero, so each captured value is the time between two successive tach falling edges, measured in prescaled ticks. Firmware turns that period into fan speed.

A control word sets four things: whether the channel runs, the divide ratio, whether captures are armed, and which flags raise the interrupt. Software can load the count at any time. A capture flag and a wrap flag stay set until software clears them. The wrap flag shows a fan that has stopped or is very slow: the counter ran through its whole range with no tach edge.

Top module: `tach_capture_timer`

## Requirements
- R1: After reset, the control word, count, capture register, both flags and `irq` are all zero. The synchroniser is preset high, so a tach line that idles high causes no capture.
- R2: While the enable bit (control bit 0) is 0, the count holds its value and no capture occurs, even if the tach line falls.
- R3: Control bits [2:1] select a divide ratio of 4^sel (1, 4, 16 or 64). Once enabled, the count advances by one every ratio system clocks. The first advance comes ratio clocks after the control write.
- R4: A count write loads `cnt_wdata` on the next clock, whether or not the channel is enabled. In that same clock the write takes priority over an increment.
- R5: When the count increments from FFFFh it becomes 0000h and `ovf_flag` is set.
- R6: Control bit 3 arms capture. With capture armed and the channel enabled, a falling edge on `tach_in` seen before clock edge k is handled at edge k+2. At that edge the capture register takes the current count, the count restarts at 0000h and `cap_flag` is set.
- R7: When a capture and a count write occur in the same clock, the capture wins and the count becomes 0000h.
- R8: With capture disarmed, tach edges leave the count, the capture register and `cap_flag` unchanged.
- R9: Each flag stays set until software pulses its clear bit (`flag_clr[0]` for capture, `flag_clr[1]` for wrap). A set in the same clock as a clear wins.
- R10: `irq` is high when `cap_flag` is set with control bit 4 set, or when `ovf_flag` is set with control bit 5 set, and is low otherwise.
- R11: A rising edge on `tach_in` causes no capture and does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_in | input | 1 | Raw fan tachometer line |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 6 | Control word: {ovf_ie, cap_ie, cap_en, div_sel[1:0], enable} |
| cnt_we | input | 1 | Count load strobe |
| cnt_wdata | input | 16 | Count load value |
| flag_clr | input | 2 | Flag clear pulses: [0] capture, [1] wrap |
| ctrl_q | output | 6 | Current control word |
| count_q | output | 16 | Running count |
| capture_q | output | 16 | Last captured count |
| cap_flag | output | 1 | Capture flag |
| ovf_flag | output | 1 | Wrap flag |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties are checked on every clock. They cover:
- a count that holds while the channel is disabled;
- a count that never moves by more than one step without a write or capture;
- the restart to zero after a capture, including when a write coincides with it;
- the wrap that raises its flag;
- flags that stay set until cleared;
- an interrupt that stays low when no flag is set.

Only the directed scenarios can show:
- the exact ratio produced by each divider setting;
- the two-clock synchroniser delay and the captured value it produces;
- rising edges and disarmed captures having no effect;
- set winning over clear.

// File: rtl/tach_capture_timer.sv
module tach_capture_timer #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2,
  localparam int CTRL_W = SEL_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tach_in,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic [1:0]        flag_clr,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  capture_q,
  output logic              cap_flag,
  output logic              ovf_flag,
  output logic              irq
);
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1);

  logic [2:0]       tach_sync;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_term;
  logic [SEL_W-1:0] div_sel;
  logic             en, cap_en, cap_ie, ovf_ie;
  logic             fall, tick, cap_hit, wrap;

  assign en      = ctrl_q[0];
  assign div_sel = ctrl_q[SEL_W:1];
  assign cap_en  = ctrl_q[SEL_W+1];
  assign cap_ie  = ctrl_q[SEL_W+2];
  assign ovf_ie  = ctrl_q[SEL_W+3];

  assign pre_term = ~({PRE_W{1'b1}} << {div_sel, 1'b0});
  assign fall     = tach_sync[2] & ~tach_sync[1];
  assign tick     = en && (pre_q == pre_term);
  assign cap_hit  = en && cap_en && fall;
  assign wrap     = tick && !cap_hit && !cnt_we && (count_q == '1);
  assign irq      = (cap_flag & cap_ie) | (ovf_flag & ovf_ie);

  always_ff @(posedge clk) begin
    if (!rst_n) tach_sync <= 3'b111;
    else        tach_sync <= {tach_sync[1:0], tach_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        pre_q <= '0;
    else if (!en || cap_hit || cnt_we) pre_q <= '0;
    else if (tick)                     pre_q <= '0;
    else                               pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      capture_q <= '0;
    end else if (cap_hit) begin
      capture_q <= count_q;
      count_q   <= '0;
    end else if (cnt_we) begin
      count_q   <= cnt_wdata;
    end else if (tick) begin
      count_q   <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (cap_hit)          cap_flag <= 1'b1;
      else if (flag_clr[0]) cap_flag <= 1'b0;
      if (wrap)             ovf_flag <= 1'b1;
      else if (flag_clr[1]) ovf_flag <= 1'b0;
    end
  end

  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !cnt_we |=> $stable(count_q) && $stable(capture_q));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we && !cap_hit |=> CNT_W'(count_q - $past(count_q)) <= CNT_W'(1));

  a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_we && !cap_hit && count_q == '1 |=> ovf_flag && count_q == '0);

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> count_q == '0 && cap_flag && capture_q == $past(count_q));

  a_r7_capture_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit && cnt_we |=> count_q == '0);

  a_r9_cap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag && !flag_clr[0] |=> cap_flag);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !flag_clr[1] |=> ovf_flag);

  a_r10_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_flag && !ovf_flag |-> !irq);
endmodule

// File: tb/tach_capture_timer_tb.sv
module tach_capture_timer_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tach_in = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [5:0]  ctrl_wdata = '0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic [1:0]  flag_clr = '0;
  logic [5:0]  ctrl_q;
  logic [15:0] count_q, capture_q;
  logic        cap_flag, ovf_flag, irq;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  tach_capture_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr),
    .ctrl_q(ctrl_q), .count_q(count_q), .capture_q(capture_q),
    .cap_flag(cap_flag), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // control word: {ovf_ie, cap_ie, cap_en, sel[1:0], en}
  task automatic set_ctrl(input logic en, input logic [1:0] sel, input logic cap,
                          input logic cie, input logic oie);
    ctrl_wdata = {oie, cie, cap, sel, en};
    ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic load_cnt(input logic [15:0] v);
    cnt_wdata = v;
    cnt_we = 1'b1;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 count", count_q, 0);
    chk("R1 capture", capture_q, 0);
    chk("R1 flags/irq", {cap_flag, ovf_flag, irq}, 0);
  endtask

  task automatic t_disabled;
    load_cnt(16'h1234);
    chk("R4 load while off", count_q, 16'h1234);
    wait_n(10);
    chk("R2 count holds", count_q, 16'h1234);
    set_ctrl(1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    tach_in = 1'b0;
    wait_n(5);
    chk("R2 no capture", capture_q, 0);
    chk("R2 no flag", cap_flag, 0);
    chk("R2 count still", count_q, 16'h1234);
    tach_in = 1'b1;
    wait_n(4);
  endtask

  task automatic t_divider;
    for (int s = 0; s < 4; s++) begin
      int r;
      r = 1 << (2 * s);
      set_ctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
      load_cnt(16'h0000);
      set_ctrl(1'b1, 2'(s), 1'b0, 1'b0, 1'b0);
      wait_n(5 * r - 1);
      chk($sformatf("R3 sel=%0d before step", s), count_q, 4);
      wait_n(1);
      chk($sformatf("R3 sel=%0d step", s), count_q, 5);
    end
  endtask

  task automatic t_wrap;
    set_ctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    load_cnt(16'hFFFE);
    set_ctrl(1'b1, 2'd0, 1'b0, 1'b0, 1'b1);
    wait_n(1);
    chk("R5 at max", count_q, 16'hFFFF);
    chk("R5 no flag yet", ovf_flag, 0);
    wait_n(1);
    chk("R5 wrapped", count_q, 16'h0000);
    chk("R5 flag set", ovf_flag, 1);
    chk("R10 ovf irq", irq, 1);
    wait_n(3);
    chk("R9 ovf sticky", ovf_flag, 1);
    flag_clr = 2'b10;
    @(negedge clk);
    flag_clr = 2'b00;
    chk("R9 ovf cleared", ovf_flag, 0);
    chk("R10 irq dropped", irq, 0);
  endtask

  task automatic t_capture;
    set_ctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    load_cnt(16'h0000);
    set_ctrl(1'b1, 2'd0, 1'b1, 1'b1, 1'b0);
    wait_n(10);
    chk("R6 pre count", count_q, 10);
    tach_in = 1'b0;
    wait_n(2);
    chk("R6 not yet captured", capture_q, 0);
    chk("R6 no flag yet", cap_flag, 0);
    wait_n(1);
    chk("R6 captured value", capture_q, 12);
    chk("R6 restart", count_q, 0);
    chk("R6 flag", cap_flag, 1);
    chk("R10 cap irq", irq, 1);
    wait_n(1);
    chk("R6 keeps counting", count_q, 1);
    tach_in = 1'b1;
    wait_n(6);
    chk("R11 rise no capture", capture_q, 12);
    chk("R11 rise no restart", count_q, 7);
    tach_in = 1'b0;
    wait_n(3);
    chk("R6 second period", capture_q, 9);
    chk("R9 cap sticky", cap_flag, 1);
    flag_clr = 2'b01;
    @(negedge clk);
    flag_clr = 2'b00;
    chk("R9 cap cleared", cap_flag, 0);
    chk("R10 irq low", irq, 0);
  endtask

  task automatic t_disarmed;
    set_ctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    tach_in = 1'b1;
    wait_n(4);
    load_cnt(16'h0020);
    set_ctrl(1'b1, 2'd0, 1'b0, 1'b1, 1'b0);
    wait_n(4);
    chk("R8 counting", count_q, 16'h0024);
    tach_in = 1'b0;
    wait_n(5);
    chk("R8 count unaffected", count_q, 16'h0029);
    chk("R8 capture unchanged", capture_q, 9);
    chk("R8 no flag", cap_flag, 0);
    load_cnt(16'h0100);
    chk("R4 write beats inc", count_q, 16'h0100);
    wait_n(1);
    chk("R4 resumes", count_q, 16'h0101);
  endtask

  task automatic t_collide;
    set_ctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    tach_in = 1'b1;
    wait_n(4);
    load_cnt(16'h0040);
    set_ctrl(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    tach_in = 1'b0;
    wait_n(2);
    cnt_wdata = 16'h5555;
    cnt_we = 1'b1;
    flag_clr = 2'b01;
    @(negedge clk);
    cnt_we = 1'b0;
    flag_clr = 2'b00;
    chk("R7 capture beats write", count_q, 0);
    chk("R7 captured", capture_q, 16'h0042);
    chk("R9 set beats clear", cap_flag, 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_disabled();
    t_divider();
    t_wrap();
    t_capture();
    t_disarmed();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule